// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Timer

This block produces the bit-level time slots that a master needs on a single-wire, open-drain bus with a pull-up resistor. A controller gives it one command at a time. The command asks for a reset/presence cycle, a write-one slot, a write-zero slot or a read slot. The block pulls the line low through an open-drain enable and watches the line through a synchronizer. When the operation ends it raises a one-cycle done pulse together with a result bit. For a reset, the result is the presence flag. For a slot, it is the line level sampled at the read point.

Every interval is a whole number of clock ticks. The ticks come from a ticks-per-microsecond parameter and per-interval microsecond parameters. Overdrive mode divides each interval by ten and rounds up to a whole tick. Before a reset pulse the line must stay released for a recovery period. In overdrive this period is always stretched to 2.5 times the minimum recovery. At standard speed the stretch is requested by a command bit. The speed and stretch inputs are captured when the command is accepted.

The controller is a state machine:
- States: `ST_IDLE`, `ST_PRE_REC` (released, pre-reset recovery), `ST_RST_LOW` (reset pulse), `ST_PRES_WIN` (released, presence window), `ST_PRES_REC` (released, post-presence recovery), `ST_SLOT` (time slot, low phase then released phase) and `ST_SLOT_REC` (released, inter-slot recovery).
- Transitions:
  - IDLE→PRE_REC on an accepted reset.
  - IDLE→SLOT on an accepted write or read.
  - PRE_REC→RST_LOW, RST_LOW→PRES_WIN, PRES_WIN→PRES_REC and SLOT→SLOT_REC when the current interval ends.
  - PRES_REC→IDLE and SLOT_REC→IDLE when the recovery ends, together with the done pulse.

Top module: `swb_slot_engine`

## Requirements
- R1: `cmd_ready` is high only in the idle state. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. A `cmd_valid` raised while the engine is busy is ignored and starts no later operation.
- R2: The `cmd_op` encoding is 00 = reset/presence, 01 = write-one, 10 = write-zero, 11 = read. Each operation ends with `done` high for exactly one cycle, with `result` valid in that cycle.
- R3: In a write-one slot, the line is pulled low for W1_LOW ticks (6 µs) and then released. Done follows SLOT + REC ticks (65 µs + 5 µs) after acceptance.
- R4: In a write-zero slot, the line is pulled low for W0_LOW ticks (60 µs). The slot and recovery lengths are the same as in R3.
- R5: In a read slot, the line is pulled low for RD_LOW ticks (6 µs) and then released. `result` is the synchronized line level at 15 µs from the slot start. A slave holding the line low past that point yields 0. A slave that has already released the line yields 1. Write slots report the same sample.
- R6: A reset pulls the line low for 480 µs. It then releases the line for a 300 µs presence window and a 180 µs recovery. `result` is 1 when the synchronized line is low at the midpoint of the presence window, and 0 otherwise.
- R7: Before the reset pulse, the line stays released for the minimum recovery (5 µs) at standard speed with `cmd_ext_rec` low. It stays released for ceil(2.5 × minimum recovery) when `cmd_ext_rec` is high, or at any time in overdrive.
- R8: With `cmd_overdrive` high, every interval is ceil(standard ticks / 10).
- R9: Speed and stretch are captured at acceptance. Changing `cmd_overdrive`, `cmd_ext_rec` or `cmd_op` during an operation does not change its timing.
- R10: The line is released (`bus_pull_low` low) whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | Operation code (see R2) |
| cmd_overdrive | input | 1 | 1 = overdrive timing |
| cmd_ext_rec | input | 1 | 1 = stretched pre-reset recovery at standard speed |
| bus_line_in | input | 1 | Raw bus line level |
| bus_pull_low | output | 1 | Open-drain enable, 1 pulls the line low |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Presence flag or sampled bit, valid with done |

## Verification
The bench targets the following corner cases:
- **Read sampling point.** A slave releases the line well before the read point in one case and holds it past the read point in another. A sample taken early or late, or taken without the synchronizer, flips one of these results.
- **Pre-reset recovery.** The recovery is measured in three configurations: standard, standard with stretch, and overdrive without the stretch bit. A design that ignores the stretch bit, or that does not force the stretch in overdrive, shows the wrong delay before the line falls.
- **Mode capture.** The mode and opcode inputs are flipped as soon as each command is accepted. A design that does not capture them at acceptance stretches or shortens the slot in progress.
- **Busy commands.** A command pulsed during a busy period must be dropped. A design that queues it starts a stray operation after done.

// File: rtl/swb_pkg.sv
package swb_pkg;
    localparam int TW = 24;
    typedef logic [TW-1:0] tick_t;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WR1   = 2'b01,
        OP_WR0   = 2'b10,
        OP_READ  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_REC,
        ST_RST_LOW,
        ST_PRES_WIN,
        ST_PRES_REC,
        ST_SLOT,
        ST_SLOT_REC
    } state_e;

    typedef struct packed {
        tick_t rst_low;
        tick_t pres_win;
        tick_t pres_rec;
        tick_t slot_len;
        tick_t w1_low;
        tick_t w0_low;
        tick_t rd_low;
        tick_t rd_sample;
        tick_t rec_min;
        tick_t rec_ext;
    } tset_t;

    // Microseconds to ticks; overdrive divides by ten and rounds up.
    function automatic tick_t scale(int unsigned us, int unsigned tpu, bit od);
        int unsigned raw;
        raw = us * tpu;
        if (od) return tick_t'((raw + 9) / 10);
        return tick_t'(raw);
    endfunction
endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/swb_timing.sv
module swb_timing
    import swb_pkg::*;
#(
    parameter int unsigned TPU          = 200,
    parameter int unsigned RST_LOW_US   = 480,
    parameter int unsigned PRES_WIN_US  = 300,
    parameter int unsigned PRES_REC_US  = 180,
    parameter int unsigned SLOT_US      = 65,
    parameter int unsigned W1_LOW_US    = 6,
    parameter int unsigned W0_LOW_US    = 60,
    parameter int unsigned RD_LOW_US    = 6,
    parameter int unsigned RD_SAMPLE_US = 15,
    parameter int unsigned REC_US       = 5
) (
    input  logic  od,
    output tset_t tset
);
    tset_t sets [2];

    for (genvar g = 0; g < 2; g++) begin : g_mode
        localparam bit    OD   = (g == 1);
        localparam tick_t RECM = scale(REC_US, TPU, OD);
        assign sets[g] = '{
            rst_low:   scale(RST_LOW_US,   TPU, OD),
            pres_win:  scale(PRES_WIN_US,  TPU, OD),
            pres_rec:  scale(PRES_REC_US,  TPU, OD),
            slot_len:  scale(SLOT_US,      TPU, OD),
            w1_low:    scale(W1_LOW_US,    TPU, OD),
            w0_low:    scale(W0_LOW_US,    TPU, OD),
            rd_low:    scale(RD_LOW_US,    TPU, OD),
            rd_sample: scale(RD_SAMPLE_US, TPU, OD),
            rec_min:   RECM,
            rec_ext:   tick_t'((5 * int'(RECM) + 1) / 2)
        };
    end

    assign tset = sets[od];
endmodule

// File: rtl/swb_slot_fsm.sv
module swb_slot_fsm
    import swb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_op,
    input  logic       cmd_od,
    input  logic       cmd_ext,
    input  logic       line_s,
    input  tset_t      tset,
    output logic       od_q,
    output logic       drive_low,
    output logic       done,
    output logic       result
);
    state_e state, state_n;
    tick_t  cnt;
    op_e    op_q;
    logic   ext_q;
    logic   done_n, drive_n;
    tick_t  pre_len, low_len;
    logic   accept;

    assign accept    = cmd_valid && (state == ST_IDLE);
    assign cmd_ready = (state == ST_IDLE);
    assign pre_len   = (od_q || ext_q) ? tset.rec_ext : tset.rec_min;

    always_comb begin
        unique case (op_q)
            OP_WR1:  low_len = tset.w1_low;
            OP_WR0:  low_len = tset.w0_low;
            OP_READ: low_len = tset.rd_low;
            default: low_len = '0;
        endcase
    end

    // Next state and done
    always_comb begin
        state_n = state;
        done_n  = 1'b0;
        unique case (state)
            ST_IDLE:
                if (accept) state_n = (op_e'(cmd_op) == OP_RESET) ? ST_PRE_REC : ST_SLOT;
            ST_PRE_REC:
                if (cnt == pre_len - 1'b1) state_n = ST_RST_LOW;
            ST_RST_LOW:
                if (cnt == tset.rst_low - 1'b1) state_n = ST_PRES_WIN;
            ST_PRES_WIN:
                if (cnt == tset.pres_win - 1'b1) state_n = ST_PRES_REC;
            ST_PRES_REC:
                if (cnt == tset.pres_rec - 1'b1) begin
                    state_n = ST_IDLE;
                    done_n  = 1'b1;
                end
            ST_SLOT:
                if (cnt == tset.slot_len - 1'b1) state_n = ST_SLOT_REC;
            ST_SLOT_REC:
                if (cnt == tset.rec_min - 1'b1) begin
                    state_n = ST_IDLE;
                    done_n  = 1'b1;
                end
            default: state_n = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_RST_LOW: drive_n = 1'b1;
            ST_SLOT:    drive_n = (cnt < low_len);
            default:    drive_n = 1'b0;
        endcase
    end

    // State register and captured command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            op_q      <= OP_RESET;
            od_q      <= 1'b0;
            ext_q     <= 1'b0;
            done      <= 1'b0;
            drive_low <= 1'b0;
            result    <= 1'b0;
        end else begin
            state     <= state_n;
            cnt       <= (state_n != state) ? '0 : cnt + 1'b1;
            done      <= done_n;
            drive_low <= drive_n;
            if (accept) begin
                op_q  <= op_e'(cmd_op);
                od_q  <= cmd_od;
                ext_q <= cmd_ext;
            end
            if (state == ST_PRES_WIN && cnt == (tset.pres_win >> 1))
                result <= ~line_s;
            if (state == ST_SLOT && cnt == tset.rd_sample)
                result <= line_s;
        end
    end

    p_accept_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> $stable(od_q));

    p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !drive_low);

    p_reset_pulls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST_LOW && cnt != '0) |-> drive_low);
endmodule

// File: rtl/swb_slot_engine.sv
module swb_slot_engine
    import swb_pkg::*;
#(
    parameter int unsigned TICKS_PER_US = 200,
    parameter int unsigned RST_LOW_US   = 480,
    parameter int unsigned PRES_WIN_US  = 300,
    parameter int unsigned PRES_REC_US  = 180,
    parameter int unsigned SLOT_US      = 65,
    parameter int unsigned W1_LOW_US    = 6,
    parameter int unsigned W0_LOW_US    = 60,
    parameter int unsigned RD_LOW_US    = 6,
    parameter int unsigned RD_SAMPLE_US = 15,
    parameter int unsigned REC_US       = 5,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_op,
    input  logic       cmd_overdrive,
    input  logic       cmd_ext_rec,
    input  logic       bus_line_in,
    output logic       bus_pull_low,
    output logic       done,
    output logic       result
);
    logic  line_s;
    logic  od_q;
    tset_t tset;

    swb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_line_in),
        .q     (line_s)
    );

    swb_timing #(
        .TPU          (TICKS_PER_US),
        .RST_LOW_US   (RST_LOW_US),
        .PRES_WIN_US  (PRES_WIN_US),
        .PRES_REC_US  (PRES_REC_US),
        .SLOT_US      (SLOT_US),
        .W1_LOW_US    (W1_LOW_US),
        .W0_LOW_US    (W0_LOW_US),
        .RD_LOW_US    (RD_LOW_US),
        .RD_SAMPLE_US (RD_SAMPLE_US),
        .REC_US       (REC_US)
    ) u_timing (
        .od   (od_q),
        .tset (tset)
    );

    swb_slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_od    (cmd_overdrive),
        .cmd_ext   (cmd_ext_rec),
        .line_s    (line_s),
        .tset      (tset),
        .od_q      (od_q),
        .drive_low (bus_pull_low),
        .done      (done),
        .result    (result)
    );
endmodule

// File: tb/sim_swb_slot_engine.sv
`timescale 1ns/1ps
module sim_swb_slot_engine;
    localparam int TPU = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'b00;
    logic       cmd_overdrive = 1'b0;
    logic       cmd_ext_rec = 1'b0;
    logic       bus_line_in;
    logic       bus_pull_low;
    logic       done;
    logic       result;
    logic       slave_low = 1'b0;

    int checks = 0;
    int failures = 0;
    int m_first, m_width, m_done;
    logic m_res;
    bit finished = 0;

    always #2.5 clk = ~clk;
    assign bus_line_in = !(bus_pull_low || slave_low);

    swb_slot_engine #(.TICKS_PER_US(TPU)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_overdrive(cmd_overdrive), .cmd_ext_rec(cmd_ext_rec),
        .bus_line_in(bus_line_in), .bus_pull_low(bus_pull_low),
        .done(done), .result(result)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one command, then measure the line and the done pulse.
    task automatic run_cmd(input logic [1:0] op, input logic od, input logic ext, input bit poke);
        bit got;
        @(negedge clk);
        cmd_op = op; cmd_overdrive = od; cmd_ext_rec = ext; cmd_valid = 1'b1;
        check(cmd_ready == 1'b1, "R1 ready before accept", int'(cmd_ready), 1);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cmd_overdrive = ~od; cmd_ext_rec = ~ext; cmd_op = ~op;  // R9: inputs flip mid-op
        m_first = 0; m_width = 0; m_done = 0; m_res = 1'b0; got = 0;
        for (int n = 1; n <= 20000 && !got; n++) begin
            if (poke && n == 5) cmd_valid = 1'b1;
            @(posedge clk); #1;
            if (poke && n == 5) cmd_valid = 1'b0;
            if (bus_pull_low) begin
                if (m_first == 0) m_first = n;
                m_width++;
            end
            if (done) begin
                m_done = n; m_res = result; got = 1;
            end
        end
        check(got, "R2 done seen (watchdog)", int'(got), 1);
        @(posedge clk); #1;
        check(!done, "R2 done single cycle", int'(done), 0);
    endtask

    task automatic t_reset_state();
        check(cmd_ready === 1'b1, "R1 reset ready", int'(cmd_ready), 1);
        check(bus_pull_low === 1'b0, "R10 reset released", int'(bus_pull_low), 0);
        check(done === 1'b0, "R2 reset done low", int'(done), 0);
    endtask

    task automatic t_write1_std();
        run_cmd(2'b01, 1'b0, 1'b0, 0);
        check(m_first == 1, "R3 w1 start", m_first, 1);
        check(m_width == 24, "R3 w1 low width", m_width, 24);
        check(m_done == 280, "R3 w1 length", m_done, 280);
        check(m_res == 1'b1, "R5 w1 sample", int'(m_res), 1);
    endtask

    task automatic t_write0_std();
        run_cmd(2'b10, 1'b0, 1'b0, 0);
        check(m_width == 240, "R4 w0 low width", m_width, 240);
        check(m_done == 280, "R4 w0 length", m_done, 280);
        check(m_res == 1'b0, "R4 w0 sample", int'(m_res), 0);
    endtask

    task automatic t_read_std(input int hold, input logic exp);
        fork
            begin
                if (hold > 0) begin
                    @(posedge bus_pull_low);
                    slave_low = 1'b1;
                    repeat (hold) @(posedge clk);
                    slave_low = 1'b0;
                end
            end
        join_none
        run_cmd(2'b11, 1'b0, 1'b0, 0);
        check(m_width == 24, "R5 read low width", m_width, 24);
        check(m_done == 280, "R5 read length", m_done, 280);
        check(m_res == exp, "R5 read bit", int'(m_res), int'(exp));
    endtask

    task automatic t_reset_cycle(input logic od, input logic ext, input bit slave,
                                 input int a, input int b, input int exp_first,
                                 input int exp_width, input int exp_done);
        fork
            begin
                if (slave) begin
                    @(negedge bus_pull_low);
                    repeat (a) @(posedge clk);
                    slave_low = 1'b1;
                    repeat (b) @(posedge clk);
                    slave_low = 1'b0;
                end
            end
        join_none
        run_cmd(2'b00, od, ext, 0);
        check(m_first == exp_first, "R7 pre-reset recovery", m_first, exp_first);
        check(m_width == exp_width, "R6 reset low width", m_width, exp_width);
        check(m_done == exp_done, "R6 reset cycle length", m_done, exp_done);
        check(m_res == slave, "R6 presence flag", int'(m_res), int'(slave));
    endtask

    task automatic t_overdrive_slots();
        run_cmd(2'b01, 1'b1, 1'b0, 0);
        check(m_width == 3, "R8 od w1 low", m_width, 3);
        check(m_done == 28, "R8 od slot length", m_done, 28);
        run_cmd(2'b10, 1'b1, 1'b0, 0);
        check(m_width == 24, "R8 od w0 low", m_width, 24);
        fork
            begin
                @(posedge bus_pull_low);
                slave_low = 1'b1;
                repeat (12) @(posedge clk);
                slave_low = 1'b0;
            end
        join_none
        run_cmd(2'b11, 1'b1, 1'b0, 0);
        check(m_res == 1'b0, "R8 od read zero", int'(m_res), 0);
        check(m_done == 28, "R9 od read length", m_done, 28);
    endtask

    task automatic t_busy_ignore();
        run_cmd(2'b01, 1'b0, 1'b0, 1);
        check(m_done == 280, "R1 busy poke no effect on slot", m_done, 280);
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #1;
            if (bus_pull_low || !cmd_ready) begin
                check(0, "R1 busy command ignored", int'(bus_pull_low), 0);
                break;
            end
        end
        check(cmd_ready && !bus_pull_low, "R10 idle after busy poke", int'(bus_pull_low), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_write1_std();
        t_write0_std();
        t_read_std(0, 1'b1);
        t_read_std(120, 1'b0);
        t_read_std(40, 1'b1);
        t_reset_cycle(1'b0, 1'b0, 1'b1, 120, 840, 21, 1920, 3860);
        t_reset_cycle(1'b0, 1'b1, 1'b0, 0, 0, 51, 1920, 3890);
        t_reset_cycle(1'b1, 1'b0, 1'b1, 12, 84, 6, 192, 389);
        t_overdrive_slots();
        t_busy_ignore();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule